// File: doc/BRIEF.md
# Implicit Return Call Tracker

This block sits beside an instruction trace encoder. It decides, for every retired function return, whether the return's destination can be left out of the trace. A return can be left out only when the matching call has already been reported, so the decoder can rebuild the destination itself. The encoder gives the block one retired instruction per valid cycle. Each instruction comes with a class code, its actual target address, the address of the instruction that follows it, and a strobe that marks the cycle in which a synchronization packet goes out.

The block is built in one of two variants, chosen by a parameter. The counter variant keeps a saturating count of nested calls that have been reported. It does not look at addresses. The stack variant keeps a small circular stack of expected return addresses. A return is inferable only when its real target equals the address on top of the stack. When a return cannot be inferred, the block raises a report flag and gives the number of entries held before the return. The encoder places that number in the explicit packet.

Top module: `ret_trk`

## Requirements
- R1: Every instruction accepted with `in_valid` high gives exactly one result, with `out_valid` high on the following cycle. For a class other than return (00 other, 01 call, 10 tail call), `out_ret`, `out_inferable` and `out_report` are low and `out_depth` is 0. Class 11 is a return.
- R2: Counter variant: a call (01) adds one to the nesting count, a return (11) subtracts one, and a tail call (10) or other (00) leaves the count unchanged. The count held before a return is shown on `out_depth`.
- R3: Counter variant: the count stops at 2^CNT_W-1 when calls continue, and it never goes below 0.
- R4: Counter variant: a return is inferable exactly when the count is non-zero. Its target address is not checked.
- R5: Stack variant: a call pushes `in_next_pc`. A return is inferable exactly when the stack is non-empty and `in_target` equals the top entry.
- R6: For each return, exactly one of `out_inferable` and `out_report` is high. `out_depth` gives the number of entries (or the count) held just before that return.
- R7: Stack variant: a return removes the top entry whether or not its target matched.
- R8: A return that meets an empty stack or a zero count is reported with depth 0.
- R9: While `in_sync` is high, the count and stack are emptied first. The instruction in the same cycle is judged against the empty state, and its own effect is then applied.
- R10: Stack variant: a call made when STK_DEPTH entries are held drops the oldest entry. The depth stays at STK_DEPTH.
- R11: After reset, `out_valid` is low and the tracker is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A retired instruction is presented |
| in_class | input | 2 | 00 other, 01 call, 10 tail call, 11 return |
| in_target | input | ADDR_W | Actual target of the instruction |
| in_next_pc | input | ADDR_W | Address of the instruction after this one |
| in_sync | input | 1 | Synchronization packet sent this cycle |
| out_valid | output | 1 | Result for the previous cycle's instruction |
| out_ret | output | 1 | That instruction was a return |
| out_inferable | output | 1 | The return may be omitted from the trace |
| out_report | output | 1 | The return must be reported explicitly |
| out_depth | output | DEPTH_W | Entries or count held before the return |

## Verification
The bench runs both variants side by side on the same stimulus and compares each against a queue-based model. It targets the following cases:
- A return whose target differs from the top entry. A design that skipped the compare would mark it inferable.
- A return after a mismatch. A design that failed to pop on mismatch would pair later returns with stale entries.
- Call runs that overfill the stack and the counter. A design that wraps would report depth 0 or fail on the deepest returns.
- A tail call followed by a return. A design that counts the tail call would suppress that return.
- Sync arriving in the same cycle as a call or a return. A design that applies sync after the instruction would keep stale depth.

// File: rtl/ret_trk_pkg.sv
// Package: shared class encoding for the return tracker.
// Assumes the instruction classifier upstream produces these codes.
package ret_trk_pkg;
    typedef enum logic [1:0] {
        CLS_OTHER = 2'b00,
        CLS_CALL  = 2'b01,
        CLS_TAIL  = 2'b10,
        CLS_RET   = 2'b11
    } instr_cls_e;
endpackage

// File: rtl/ret_trk_counter.sv
// Saturating nesting counter for the address-blind variant.
// Shows the count as seen by the current instruction (already cleared when
// sync is high). Assumes one instruction per valid cycle.
module ret_trk_counter
    import ret_trk_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  instr_cls_e       cls,
    input  logic             sync,
    output logic [CNT_W-1:0] cnt_eff
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Count seen by this cycle's instruction after any sync clear.
    assign cnt_eff = sync ? '0 : cnt_q;

    // Count update: saturating increment on call, floored decrement on return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (valid) begin
            case (cls)
                CLS_CALL: cnt_q <= (cnt_eff == CNT_MAX) ? CNT_MAX : cnt_eff + 1'b1;
                CLS_RET:  cnt_q <= (cnt_eff == '0) ? '0 : cnt_eff - 1'b1;
                default:  cnt_q <= cnt_eff;
            endcase
        end else begin
            cnt_q <= cnt_eff;
        end
    end
endmodule

// File: rtl/ret_trk_stack.sv
// Circular stack of expected return addresses. When full, a push overwrites
// the oldest entry and the count stays at STK_DEPTH. A pop happens on every
// return that finds the stack non-empty. Assumes STK_DEPTH >= 2.
module ret_trk_stack
    import ret_trk_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int STK_DEPTH = 4,
    localparam int PTR_W    = $clog2(STK_DEPTH),
    localparam int CNT_W    = $clog2(STK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  instr_cls_e        cls,
    input  logic              sync,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] top_addr,
    output logic [CNT_W-1:0]  depth_eff
);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(STK_DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(STK_DEPTH);

    logic [ADDR_W-1:0] mem [STK_DEPTH];
    logic [PTR_W-1:0]  top_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PTR_W-1:0]  ptr_up;
    logic [PTR_W-1:0]  ptr_dn;
    logic              do_push;
    logic              do_pop;

    // Pointer neighbours with wrap at the configured depth.
    always_comb begin
        ptr_up = (top_q == PTR_LAST) ? '0 : top_q + 1'b1;
        ptr_dn = (top_q == '0) ? PTR_LAST : top_q - 1'b1;
    end

    assign depth_eff = sync ? '0 : cnt_q;
    assign top_addr  = mem[top_q];
    assign do_push   = valid && (cls == CLS_CALL);
    assign do_pop    = valid && (cls == CLS_RET) && (depth_eff != '0);

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
            cnt_q <= '0;
        end else if (do_push) begin
            top_q <= ptr_up;
            cnt_q <= (depth_eff == CNT_FULL) ? CNT_FULL : depth_eff + 1'b1;
        end else if (do_pop) begin
            top_q <= ptr_dn;
            cnt_q <= depth_eff - 1'b1;
        end else begin
            cnt_q <= depth_eff;
        end
    end

    // Entry storage: write the return address into the slot above the top.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[ptr_up] <= push_addr;
        end
    end
endmodule

// File: rtl/ret_trk.sv
// Top of the implicit return tracker. USE_STACK selects the address stack
// (1) or the plain nesting counter (0). One registered result per valid
// instruction, one cycle later. Assumes in_class is meaningful only with
// in_valid and that in_sync marks the cycle whose packet carries a full sync.
module ret_trk
    import ret_trk_pkg::*;
#(
    parameter int  ADDR_W    = 32,
    parameter int  CNT_W     = 3,
    parameter int  STK_DEPTH = 4,
    parameter bit  USE_STACK = 1'b1,
    localparam int DEPTH_W   = USE_STACK ? $clog2(STK_DEPTH + 1) : CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_class,
    input  logic [ADDR_W-1:0]  in_target,
    input  logic [ADDR_W-1:0]  in_next_pc,
    input  logic               in_sync,
    output logic               out_valid,
    output logic               out_ret,
    output logic               out_inferable,
    output logic               out_report,
    output logic [DEPTH_W-1:0] out_depth
);
    instr_cls_e         cls;
    logic               is_ret;
    logic               infer_now;
    logic [DEPTH_W-1:0] depth_now;

    assign cls    = instr_cls_e'(in_class);
    assign is_ret = in_valid && (cls == CLS_RET);

    generate
        if (USE_STACK) begin : g_stack
            logic [ADDR_W-1:0] top_addr;
            // Address-checked decision.
            ret_trk_stack #(
                .ADDR_W   (ADDR_W),
                .STK_DEPTH(STK_DEPTH)
            ) u_stack (
                .clk      (clk),
                .rst_n    (rst_n),
                .valid    (in_valid),
                .cls      (cls),
                .sync     (in_sync),
                .push_addr(in_next_pc),
                .top_addr (top_addr),
                .depth_eff(depth_now)
            );
            assign infer_now = (depth_now != '0) && (top_addr == in_target);
        end else begin : g_count
            // Count-only decision; target is not consulted.
            ret_trk_counter #(
                .CNT_W(CNT_W)
            ) u_count (
                .clk    (clk),
                .rst_n  (rst_n),
                .valid  (in_valid),
                .cls    (cls),
                .sync   (in_sync),
                .cnt_eff(depth_now)
            );
            assign infer_now = (depth_now != '0);
        end
    endgenerate

    // Result register: one cycle after the instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid     <= 1'b0;
            out_ret       <= 1'b0;
            out_inferable <= 1'b0;
            out_report    <= 1'b0;
            out_depth     <= '0;
        end else begin
            out_valid     <= in_valid;
            out_ret       <= is_ret;
            out_inferable <= is_ret && infer_now;
            out_report    <= is_ret && !infer_now;
            out_depth     <= is_ret ? depth_now : '0;
        end
    end
endmodule

// File: rtl/ret_trk_chk.sv
// Checker for ret_trk, attached by bind. Watches ports only.
module ret_trk_chk #(
    parameter int DEPTH_W   = 3,
    parameter int MAX_DEPTH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               in_valid,
    input logic [1:0]         in_class,
    input logic               in_sync,
    input logic               out_valid,
    input logic               out_ret,
    input logic               out_inferable,
    input logic               out_report,
    input logic [DEPTH_W-1:0] out_depth
);
    // R1
    valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R1
    idle_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R1
    non_ret_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ret) |-> (!out_inferable && !out_report && out_depth == '0));
    // R6
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ret) |-> (out_inferable != out_report));
    // R9
    sync_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync && in_class == 2'b11) |=> (out_report && out_depth == '0));
    // R8
    empty_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ret && out_depth == '0) |-> out_report);
    // R10
    depth_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(out_depth) <= MAX_DEPTH);
endmodule

bind ret_trk ret_trk_chk #(
    .DEPTH_W  (DEPTH_W),
    .MAX_DEPTH(USE_STACK ? STK_DEPTH : (1 << CNT_W) - 1)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_class     (in_class),
    .in_sync      (in_sync),
    .out_valid    (out_valid),
    .out_ret      (out_ret),
    .out_inferable(out_inferable),
    .out_report   (out_report),
    .out_depth    (out_depth)
);

// File: tb/ret_trk_tb.sv
// Scoreboard bench: runs both variants on one stimulus stream.
module ret_trk_tb;
    localparam int AW    = 32;
    localparam int CW    = 2;
    localparam int SD    = 4;
    localparam int CMAX  = (1 << CW) - 1;

    typedef struct packed {
        logic       ret;
        logic       inf;
        logic       rep;
        logic [7:0] dep;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [1:0]    in_class = 2'b00;
    logic [AW-1:0] in_target = '0;
    logic [AW-1:0] in_next_pc = '0;
    logic          in_sync = 1'b0;

    logic       s_valid, s_ret, s_inf, s_rep;
    logic [2:0] s_dep;
    logic       c_valid, c_ret, c_inf, c_rep;
    logic [1:0] c_dep;

    exp_t  q_s[$];
    exp_t  q_c[$];
    string t_s[$];
    string t_c[$];

    int n_cmp = 0;
    int n_bad = 0;
    int cnt_m = 0;
    logic [AW-1:0] stk_m[$];

    always #5 clk = ~clk;

    ret_trk #(.ADDR_W(AW), .CNT_W(CW), .STK_DEPTH(SD), .USE_STACK(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_target(in_target), .in_next_pc(in_next_pc), .in_sync(in_sync),
        .out_valid(s_valid), .out_ret(s_ret), .out_inferable(s_inf),
        .out_report(s_rep), .out_depth(s_dep));

    ret_trk #(.ADDR_W(AW), .CNT_W(CW), .STK_DEPTH(SD), .USE_STACK(1'b0)) u_dut_cnt (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_class(in_class),
        .in_target(in_target), .in_next_pc(in_next_pc), .in_sync(in_sync),
        .out_valid(c_valid), .out_ret(c_ret), .out_inferable(c_inf),
        .out_report(c_rep), .out_depth(c_dep));

    task automatic check(input string tag, input exp_t act, input exp_t exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act ret=%b inf=%b rep=%b dep=%0d exp ret=%b inf=%b rep=%b dep=%0d",
                     tag, act.ret, act.inf, act.rep, act.dep, exp.ret, exp.inf, exp.rep, exp.dep);
        end
    endtask

    // Driver: presents one instruction and queues both models' expectations.
    task automatic drive(input logic [1:0] c, input logic [AW-1:0] tgt,
                         input logic [AW-1:0] nxt, input logic sy, input string tag);
        exp_t es, ec;
        @(negedge clk);
        in_valid = 1'b1; in_class = c; in_target = tgt; in_next_pc = nxt; in_sync = sy;
        if (sy) begin
            cnt_m = 0;
            stk_m.delete();
        end
        es = '0; ec = '0;
        if (c == 2'b11) begin
            es.ret = 1'b1; ec.ret = 1'b1;
            es.inf = (stk_m.size() != 0) && (stk_m[$] == tgt);
            es.rep = !es.inf;
            es.dep = 8'(stk_m.size());
            ec.inf = (cnt_m != 0);
            ec.rep = !ec.inf;
            ec.dep = 8'(cnt_m);
            if (stk_m.size() != 0) void'(stk_m.pop_back());
            if (cnt_m != 0) cnt_m--;
        end else if (c == 2'b01) begin
            stk_m.push_back(nxt);
            if (stk_m.size() > SD) void'(stk_m.pop_front());
            if (cnt_m < CMAX) cnt_m++;
        end
        q_s.push_back(es); t_s.push_back(tag);
        q_c.push_back(ec); t_c.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0; in_sync = 1'b0; in_class = 2'b00;
    endtask

    // Monitor: pops and compares each result away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && s_valid) begin
            if (q_s.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R1: stack variant result with nothing expected");
            end else begin
                check({"stack ", t_s.pop_front()}, {s_ret, s_inf, s_rep, 5'b0, s_dep}, q_s.pop_front());
            end
        end
        if (rst_n && c_valid) begin
            if (q_c.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R1: counter variant result with nothing expected");
            end else begin
                check({"count ", t_c.pop_front()}, {c_ret, c_inf, c_rep, 6'b0, c_dep}, q_c.pop_front());
            end
        end
    end

    // Watchdog.
    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 reset", {s_valid, s_ret, s_inf, s_rep, 5'b0, s_dep}, '0);
        check("R11 reset", {c_valid, c_ret, c_inf, c_rep, 6'b0, c_dep}, '0);
        rst_n = 1'b1;
        // R11: tracker empty after reset, R8 empty return
        drive(2'b11, 32'h40, 32'h0, 1'b0, "R8 R11 return after reset");
        drive(2'b00, 32'h0, 32'h4, 1'b0, "R1 other");
        // R5 R4 R6 R7
        drive(2'b01, 32'h800, 32'h100, 1'b0, "R1 call");
        drive(2'b01, 32'h900, 32'h200, 1'b0, "R1 call");
        drive(2'b11, 32'h200, 32'h0, 1'b0, "R5 matching return");
        drive(2'b11, 32'h999, 32'h0, 1'b0, "R4 R6 mismatch return");
        drive(2'b11, 32'h100, 32'h0, 1'b0, "R7 return after popped mismatch");
        // R2: tail call does not count
        drive(2'b10, 32'hA00, 32'h300, 1'b0, "R2 tail call");
        drive(2'b11, 32'h300, 32'h0, 1'b0, "R2 return after tail call");
        // R3 R10: overfill
        for (int i = 1; i <= 6; i++) drive(2'b01, 32'hB00, AW'(i * 16), 1'b0, "R10 call burst");
        for (int i = 6; i >= 1; i--) drive(2'b11, AW'(i * 16), 32'h0, 1'b0, "R3 R10 unwind");
        // R9: sync with call, sync with return
        drive(2'b01, 32'h0, 32'h500, 1'b0, "R9 call");
        drive(2'b01, 32'h0, 32'h600, 1'b1, "R9 call with sync");
        drive(2'b11, 32'h600, 32'h0, 1'b0, "R9 return after sync call");
        drive(2'b11, 32'h500, 32'h0, 1'b0, "R9 stale entry gone");
        drive(2'b01, 32'h0, 32'h700, 1'b0, "R9 call");
        drive(2'b11, 32'h700, 32'h0, 1'b1, "R9 return with sync");
        idle();
        drive(2'b11, 32'h700, 32'h0, 1'b0, "R9 after gap");
        // Mixed stream
        for (int i = 0; i < 400; i++) begin
            logic [1:0]    c;
            logic [AW-1:0] tg;
            c  = 2'($urandom_range(0, 3));
            tg = AW'($urandom_range(1, 8) * 4);
            if (c == 2'b11 && stk_m.size() != 0 && $urandom_range(0, 2) != 0) tg = stk_m[$];
            drive(c, tg, AW'($urandom_range(1, 8) * 4), ($urandom_range(0, 15) == 0),
                  "R2 R5 R6 R7 mixed");
            if ($urandom_range(0, 7) == 0) idle();
        end
        idle();
        repeat (4) @(negedge clk);
        if (q_s.size() != 0 || q_c.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R1: %0d / %0d results missing, expected 0", q_s.size(), q_c.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule